// File: doc/BRIEF.md
# Frame-Gated Watchdog Timer

This block guards a small embedded controller against runaway firmware. It counts a 1 ms time-base strobe. When software lets 32 ticks pass without touching the watchdog's control register, the block raises a one-cycle request to reset the CPU. After such a reset, software can read a status bit that records that the watchdog caused it.

The watchdog starts only when firmware arms it by writing a 1 to its arm bit. Even when armed, it does not count until the serial bus has shown at least one start-of-frame marker. When the CPU enters idle, counting stops. It starts again, with the count it had, once an interrupt is signalled. Power-up reset and bus reset are the only events that disarm it. The CPU reset that the block itself requests leaves it armed.

Top module: `fgwdt`

## Requirements
- R1: After power-up reset the reset request is low and every status bit reads 0. The status bits are: bit 0 armed, bit 1 watchdog-caused reset, bit 2 frame seen, bit 3 paused.
- R2: A register write with write data bit 0 set arms the watchdog. A write with bit 0 clear leaves the arm bit unchanged.
- R3: No count advances and no reset request appears until a start-of-frame strobe has been seen. The frame-seen bit stays set once it is set.
- R4: While the watchdog is armed, has seen a frame and is not paused, the 32nd tick after the last register access makes the reset request high for exactly one cycle, the cycle after that tick is sampled. The count then restarts from zero, so the next request follows 32 ticks later.
- R5: Any register access, read or write, clears the count. A tick sampled in the same cycle as an access is not counted and cannot cause a request.
- R6: A rising edge of the CPU idle input pauses counting and sets status bit 3. An interrupt strobe clears the pause. Counting then resumes from the count held at the pause.
- R7: Bus reset clears the arm bit, the frame-seen bit and the count. It leaves the watchdog-caused bit unchanged.
- R8: A reset request sets status bit 1 and leaves the arm bit set. A write with data bit 1 set clears status bit 1. A write with data bit 1 clear leaves it unchanged.
- R9: While the watchdog is not armed, no reset request is produced, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_por_n | input | 1 | Power-up reset, asynchronous, active low |
| bus_rst | input | 1 | Bus reset, synchronous, active high |
| tick | input | 1 | One-cycle strobe every 1 ms |
| sof | input | 1 | Start-of-frame detected strobe |
| cpu_idle | input | 1 | CPU idle flag level |
| irq | input | 1 | Interrupt-pending strobe |
| acc | input | 1 | Control register access strobe (read or write) |
| wr | input | 1 | Access is a write |
| wdata | input | 2 | Write data: bit 0 arm, bit 1 clear watchdog-caused flag |
| rst_req | output | 1 | One-cycle CPU reset request |
| status | output | 4 | {paused, frame seen, watchdog-caused, armed} |

## Verification
Two events can fall in the same cycle: a register access and the tick that would complete the 32-tick window. When they do, the access must win. The bench first lets 31 ticks pass, then drives the 32nd tick together with an access strobe. It expects no request in that cycle or the next. It then expects a request on exactly the 32nd of the following ticks. The same access-versus-tick race is also swept, with the access placed after every possible partial count.

// File: rtl/fgwdt.sv
module fgwdt #(
  parameter int TIMEOUT = 32
) (
  input  logic       clk,
  input  logic       rst_por_n,
  input  logic       bus_rst,
  input  logic       tick,
  input  logic       sof,
  input  logic       cpu_idle,
  input  logic       irq,
  input  logic       acc,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic       rst_req,
  output logic [3:0] status
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;
  logic armed, seen, hold, idle_q, wd_flag;
  logic run, fire;

  assign run  = armed & seen & ~hold;
  assign fire = tick & run & ~acc & ~bus_rst & (cnt == LAST);
  assign status = {hold, seen, wd_flag, armed};

  always_ff @(posedge clk or negedge rst_por_n) begin
    if (!rst_por_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      seen    <= 1'b0;
      hold    <= 1'b0;
      idle_q  <= 1'b0;
      wd_flag <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      idle_q  <= cpu_idle;
      rst_req <= fire;

      if (irq)
        hold <= 1'b0;
      else if (cpu_idle && !idle_q)
        hold <= 1'b1;

      if (bus_rst) begin
        armed <= 1'b0;
        seen  <= 1'b0;
      end else begin
        if (acc && wr && wdata[0]) armed <= 1'b1;
        if (sof) seen <= 1'b1;
      end

      if (fire)
        wd_flag <= 1'b1;
      else if (acc && wr && wdata[1])
        wd_flag <= 1'b0;

      if (bus_rst || acc || fire)
        cnt <= '0;
      else if (tick && run)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fgwdt_chk.sv
module fgwdt_chk (
  input logic       clk,
  input logic       rst_por_n,
  input logic       bus_rst,
  input logic       acc,
  input logic       rst_req,
  input logic [3:0] status
);
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_por_n)
    rst_req |=> !rst_req);
  assert_flag_on_pulse_R8: assert property (@(posedge clk) disable iff (!rst_por_n)
    rst_req |-> (status[1] && status[0]));
  assert_arm_sticky_R2: assert property (@(posedge clk) disable iff (!rst_por_n)
    (status[0] && !bus_rst) |=> status[0]);
  assert_no_pulse_disarmed_R9: assert property (@(posedge clk) disable iff (!rst_por_n)
    !status[0] |=> !rst_req);
  assert_no_pulse_unseen_R3: assert property (@(posedge clk) disable iff (!rst_por_n)
    !status[2] |=> !rst_req);
  assert_no_pulse_paused_R6: assert property (@(posedge clk) disable iff (!rst_por_n)
    status[3] |=> !rst_req);
  assert_access_blocks_R5: assert property (@(posedge clk) disable iff (!rst_por_n)
    acc |=> !rst_req);
  assert_bus_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_por_n)
    bus_rst |=> (!status[0] && !status[2]));
endmodule

bind fgwdt fgwdt_chk u_fgwdt_chk (
  .clk(clk), .rst_por_n(rst_por_n), .bus_rst(bus_rst), .acc(acc),
  .rst_req(rst_req), .status(status)
);

// File: tb/test_fgwdt.sv
`timescale 1ns/1ps
module test_fgwdt;
  logic clk = 1'b0;
  logic rst_por_n = 1'b0;
  logic bus_rst = 1'b0, tick = 1'b0, sof = 1'b0, cpu_idle = 1'b0, irq = 1'b0;
  logic acc = 1'b0, wr = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic rst_req;
  logic [3:0] status;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fgwdt #(.TIMEOUT(32)) i_fgwdt (
    .clk(clk), .rst_por_n(rst_por_n), .bus_rst(bus_rst), .tick(tick), .sof(sof),
    .cpu_idle(cpu_idle), .irq(irq), .acc(acc), .wr(wr), .wdata(wdata),
    .rst_req(rst_req), .status(status)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock with the given strobes; returns rst_req after the edge
  task automatic cyc(input logic t, input logic s, input logic a, input logic w,
                     input logic [1:0] d, input logic q, input logic b, output logic r);
    tick = t; sof = s; acc = a; wr = w; wdata = d; irq = q; bus_rst = b;
    @(posedge clk); #1;
    r = rst_req;
    tick = 0; sof = 0; acc = 0; wr = 0; wdata = 2'b00; irq = 0; bus_rst = 0;
  endtask

  task automatic idle_cyc();
    logic r;
    cyc(0, 0, 0, 0, 2'b00, 0, 0, r);
  endtask

  task automatic rd();
    logic r;
    cyc(0, 0, 1, 0, 2'b00, 0, 0, r);
  endtask

  task automatic wrt(input logic [1:0] d);
    logic r;
    cyc(0, 0, 1, 1, d, 0, 0, r);
  endtask

  // n ticks with a gap cycle between; returns index of first pulse and pulse count
  task automatic ticks(input int n, output int first, output int cnt);
    logic r;
    first = 0; cnt = 0;
    for (int i = 1; i <= n; i++) begin
      cyc(1, 0, 0, 0, 2'b00, 0, 0, r);
      if (r) begin cnt++; if (first == 0) first = i; end
      cyc(0, 0, 0, 0, 2'b00, 0, 0, r);
      if (r) begin cnt++; if (first == 0) first = -i; end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int f, c;
    logic r;
    repeat (3) @(posedge clk);
    #1 rst_por_n = 1'b1;
    idle_cyc();
    chk("R1 status after power-up", status, 0);
    chk("R1 request after power-up", rst_req, 0);

    // R9: frames seen but never armed
    cyc(0, 1, 0, 0, 2'b00, 0, 0, r);
    ticks(40, f, c);
    chk("R9 pulses while disarmed", c, 0);
    chk("R9 armed bit", status[0], 0);

    // R2/R3: arm, but clear frame-seen via bus reset then rearm without frame
    cyc(0, 0, 0, 0, 2'b00, 0, 1, r);
    wrt(2'b01);
    chk("R2 armed after write of 1", status[0], 1);
    ticks(40, f, c);
    chk("R3 pulses before frame seen", c, 0);
    chk("R3 frame-seen bit low", status[2], 0);
    cyc(0, 1, 0, 0, 2'b00, 0, 0, r);
    idle_cyc();
    chk("R3 frame-seen sticky", status[2], 1);

    // R4: pulse exactly on 32nd tick after access
    rd();
    for (int i = 1; i <= 32; i++) begin
      cyc(1, 0, 0, 0, 2'b00, 0, 0, r);
      chk("R4 request vs tick index", r, (i == 32) ? 1 : 0);
    end
    idle_cyc();
    chk("R4 request lasts one cycle", rst_req, 0);
    chk("R8 flag set after request", status[1], 1);
    chk("R8 arm kept after request", status[0], 1);
    ticks(32, f, c);
    chk("R4 restart position", f, 32);
    chk("R4 restart pulse count", c, 1);

    // R8 / R2: write 0s keep flag and arm, write bit1 clears flag
    wrt(2'b00);
    chk("R8 flag kept by write of 0", status[1], 1);
    chk("R2 arm kept by write of 0", status[0], 1);
    wrt(2'b10);
    chk("R8 flag cleared by write of 1", status[1], 0);
    chk("R8 arm kept by flag clear", status[0], 1);

    // R5: sweep access position
    for (int k = 1; k <= 31; k++) begin
      ticks(k, f, c);
      chk("R5 no pulse before access", c, 0);
      if (k % 2 == 0) rd(); else wrt(2'b00);
      ticks(32, f, c);
      chk("R5 pulse position after access", f, 32);
    end

    // R5: access coincides with completing tick
    rd();
    ticks(31, f, c);
    chk("R5 no pulse in 31 ticks", c, 0);
    cyc(1, 0, 1, 0, 2'b00, 0, 0, r);
    chk("R5 coincident access blocks request", r, 0);
    idle_cyc();
    chk("R5 no late request", rst_req, 0);
    ticks(32, f, c);
    chk("R5 window restarts after coincident access", f, 32);

    // R6: pause and resume
    rd();
    ticks(10, f, c);
    cpu_idle = 1'b1;
    idle_cyc();
    chk("R6 paused bit set", status[3], 1);
    ticks(50, f, c);
    chk("R6 no pulse while paused", c, 0);
    cpu_idle = 1'b0;
    cyc(0, 0, 0, 0, 2'b00, 1, 0, r);
    chk("R6 paused bit cleared by interrupt", status[3], 0);
    ticks(22, f, c);
    chk("R6 resumes with held count", f, 22);

    // R7: bus reset
    wrt(2'b10);
    rd();
    ticks(32, f, c);
    chk("R7 setup pulse", f, 32);
    cyc(0, 0, 0, 0, 2'b00, 0, 1, r);
    chk("R7 armed cleared", status[0], 0);
    chk("R7 frame-seen cleared", status[2], 0);
    chk("R7 flag retained", status[1], 1);
    wrt(2'b01);
    ticks(40, f, c);
    chk("R7 no count without new frame", c, 0);
    cyc(0, 1, 0, 0, 2'b00, 0, 0, r);
    ticks(32, f, c);
    chk("R7 count cleared by bus reset", f, 32);

    // R1: power-up reset again
    #1 rst_por_n = 1'b0;
    #4 rst_por_n = 1'b1;
    idle_cyc();
    chk("R1 status after second power-up", status, 0);
    chk("R1 request after second power-up", rst_req, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule